// File: doc/BRIEF.md
# Serial Programming Slave for On-Chip Code Memory

This block lets an external programmer load and inspect an on-chip code memory over a four-wire serial link while a programming request input is held high. The programmer drives a serial clock and a data-in line. The block returns read data on a data-out line and drives a plain synchronous memory port with address, write data, write strobe and registered read data. Both serial lines are sampled in the system clock domain. For this, the serial clock must run at no more than one sixteenth of the system clock.

A session opens when the request input rises. After a short quiet window the block listens for instructions. Until an enable instruction arrives, every other instruction is framed and then discarded. Single-byte instructions are four bytes long. Page instructions carry a header of two bytes, then stream a full 256-byte page. Byte writes and chip erase are self-timed, and counters model how long each lasts. While a write is in progress, a read of that same location returns a polling value. While an erase is in progress, every read returns zero.

Top module: `isp_slave`

## Requirements
- R1: Bytes move MSB first. Data-in is sampled on the rising serial clock and data-out changes on the falling serial clock. A single instruction is four bytes in this order: opcode, address high, address low, data. The address is {high[ADDR_W-9:0], low}, and bits of the high byte above that are ignored.
- R2: After the request input rises, any instruction other than enable (opcode 8'hAC in the first byte) has no effect until an enable has completed. Such an instruction reads back 8'h00 and leaves memory unchanged.
- R3: Erase (opcode 8'h8A) sets every location to 8'hFF and stays busy for max(ER_BUSY, 2^ADDR_W) cycles. While it is busy, any read returns 8'h00.
- R4: Byte write (opcode 8'h40) stores the fourth byte at the addressed location.
- R5: Byte read (opcode 8'h20) returns the addressed location on data-out during the fourth byte.
- R6: For WR_BUSY cycles after a write, a read of the last written address returns bit 7 inverted from the written byte and bits 6..0 as zero. Reads of other addresses return true data. After the busy time, the last written address also returns true data.
- R7: Page read (opcode 8'h30) takes the opcode and the page number, then returns 256 bytes, starting with byte 0 of the page and going up.
- R8: Page write (opcode 8'h50) takes the opcode and the page number, then stores 256 bytes at byte 0 upward. The next instruction is decoded only after the 256th byte.
- R9: Serial clock edges within the first GUARD_CYCLES system clocks after the request input rises are ignored.
- R10: When the request input is low, or during system reset, any partial instruction is dropped, the enabled state is cleared, data-out is 0 and no write strobe is issued.
- R11: Write instructions issued while an erase is busy leave memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| prog_req | input | 1 | Programming session request, active high |
| sck | input | 1 | Serial clock from programmer |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| mem_addr | output | ADDR_W | Code memory address |
| mem_wdata | output | 8 | Code memory write data |
| mem_we | output | 1 | Code memory write strobe |
| mem_rdata | input | 8 | Code memory read data, one cycle after address |

## Verification
If the bit counter or the page index goes wrong, the framing of every later instruction slips. The very next read returns a wrong byte on data-out, at most one instruction later. If the enabled flag or a busy counter holds a wrong value, the effect shows in the fourth byte of the next read. The read comes back as zero, as a polling value or as true data when another of these was expected. A wrong erase sweep or a stray write strobe shows up in memory contents. These are read back over the serial link after the busy time ends.

// File: rtl/isp_pkg.sv
package isp_pkg;

    typedef logic [7:0] byte_t;

    localparam int PAGE_LEN = 256;

    typedef enum logic [1:0] {
        PH_OP,
        PH_HI,
        PH_LO,
        PH_DAT
    } hdr_ph_e;

    typedef enum logic {
        MD_HDR,
        MD_PAGE
    } mode_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_EN,
        K_ERASE,
        K_RDB,
        K_WRB,
        K_RDP,
        K_WRP
    } kind_e;

    function automatic kind_e classify(
        input byte_t op,
        input byte_t c_en,
        input byte_t c_er,
        input byte_t c_rb,
        input byte_t c_wb,
        input byte_t c_rp,
        input byte_t c_wp
    );
        if (op == c_en)      return K_EN;
        else if (op == c_er) return K_ERASE;
        else if (op == c_rb) return K_RDB;
        else if (op == c_wb) return K_WRB;
        else if (op == c_rp) return K_RDP;
        else if (op == c_wp) return K_WRP;
        else                 return K_NONE;
    endfunction

endpackage

// File: rtl/isp_sampler.sv
module isp_sampler #(
    parameter int GUARD_CYCLES = 64,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic prog_act,
    input  logic sck,
    input  logic mosi,
    output logic rise_o,
    output logic fall_o,
    output logic bit_o
);
    localparam int GW = $clog2(GUARD_CYCLES + 1);

    logic [SYNC_STAGES:0]   sck_q;
    logic [SYNC_STAGES-1:0] mosi_q;
    logic [GW-1:0]          guard_q;
    logic                   armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q  <= '0;
            mosi_q <= '0;
        end else begin
            sck_q  <= {sck_q[SYNC_STAGES-1:0], sck};
            mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !prog_act)
            guard_q <= '0;
        else if (!armed)
            guard_q <= guard_q + GW'(1);
    end

    assign armed  = (guard_q == GW'(GUARD_CYCLES));
    assign rise_o = armed && prog_act && sck_q[SYNC_STAGES-1] && !sck_q[SYNC_STAGES];
    assign fall_o = armed && prog_act && !sck_q[SYNC_STAGES-1] && sck_q[SYNC_STAGES];
    assign bit_o  = mosi_q[SYNC_STAGES-1];

    AST_GUARD_QUIET: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_act) |=> !rise_o && !fall_o); // R9

endmodule

// File: rtl/isp_shifter.sv
module isp_shifter
    import isp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  prog_act,
    input  logic  rise,
    input  logic  fall,
    input  logic  bit_in,
    input  byte_t tx_byte,
    output logic  byte_done,
    output byte_t rx_byte,
    output logic  miso
);
    byte_t      rx_sr_q;
    byte_t      tx_sr_q;
    logic [2:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !prog_act) begin
            rx_sr_q   <= '0;
            tx_sr_q   <= '0;
            cnt_q     <= '0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
            miso      <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (rise) begin
                rx_sr_q <= {rx_sr_q[6:0], bit_in};
                cnt_q   <= cnt_q + 3'd1;
                if (cnt_q == 3'd7) begin
                    byte_done <= 1'b1;
                    rx_byte   <= {rx_sr_q[6:0], bit_in};
                end
            end
            if (fall) begin
                if (cnt_q == 3'd0) begin
                    miso    <= tx_byte[7];
                    tx_sr_q <= {tx_byte[6:0], 1'b0};
                end else begin
                    miso    <= tx_sr_q[7];
                    tx_sr_q <= {tx_sr_q[6:0], 1'b0};
                end
            end
        end
    end

    AST_MISO_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !prog_act |=> !miso); // R10

endmodule

// File: rtl/isp_engine.sv
module isp_engine
    import isp_pkg::*;
#(
    parameter int          ADDR_W     = 11,
    parameter int          WR_BUSY    = 1500,
    parameter int          ER_BUSY    = 4000,
    parameter logic [7:0]  OP_ENABLE  = 8'hAC,
    parameter logic [7:0]  OP_ERASE   = 8'h8A,
    parameter logic [7:0]  OP_RD_BYTE = 8'h20,
    parameter logic [7:0]  OP_WR_BYTE = 8'h40,
    parameter logic [7:0]  OP_RD_PAGE = 8'h30,
    parameter logic [7:0]  OP_WR_PAGE = 8'h50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_act,
    input  logic              byte_done,
    input  byte_t             rx_byte,
    output byte_t             tx_byte,
    output logic [ADDR_W-1:0] mem_addr,
    output byte_t             mem_wdata,
    output logic              mem_we,
    input  byte_t             mem_rdata
);
    localparam int HI_W    = ADDR_W - 8;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int ER_TIME = (ER_BUSY > DEPTH) ? ER_BUSY : DEPTH;
    localparam int WR_CW   = $clog2(WR_BUSY + 1);
    localparam int ER_CW   = $clog2(ER_TIME + 1);

    logic               enabled_q;
    mode_e              mode_q;
    hdr_ph_e            ph_q;
    kind_e              kind_q;
    logic [HI_W-1:0]    hi_q;
    byte_t              lo_q;
    byte_t              pidx_q;
    logic [WR_CW-1:0]   wr_cnt_q;
    logic [ER_CW-1:0]   er_cnt_q;
    logic [ADDR_W:0]    sweep_q;
    logic [ADDR_W-1:0]  poll_addr_q;
    byte_t              poll_dat_q;
    logic [ADDR_W-1:0]  wa_q;
    byte_t              wd_q;
    logic               we_q;

    logic               wr_busy;
    logic               er_busy;
    logic               sweep_on;
    logic               reading;
    logic [ADDR_W-1:0]  cur_addr;
    logic [ADDR_W-1:0]  page_waddr;

    assign wr_busy    = (wr_cnt_q != '0);
    assign er_busy    = (er_cnt_q != '0);
    assign sweep_on   = er_busy && !sweep_q[ADDR_W];
    assign cur_addr   = (mode_q == MD_PAGE) ? {hi_q, pidx_q} : {hi_q, lo_q};
    assign page_waddr = {hi_q, pidx_q};
    assign reading    = enabled_q &&
                        (((mode_q == MD_PAGE) && (kind_q == K_RDP)) ||
                         ((mode_q == MD_HDR) && (ph_q == PH_DAT) && (kind_q == K_RDB)));

    always_comb begin
        if (!reading || er_busy)
            tx_byte = 8'h00;
        else if (wr_busy && (cur_addr == poll_addr_q))
            tx_byte = {~poll_dat_q[7], 7'b0};
        else
            tx_byte = mem_rdata;
    end

    assign mem_we    = sweep_on || we_q;
    assign mem_wdata = sweep_on ? 8'hFF : wd_q;
    assign mem_addr  = sweep_on ? sweep_q[ADDR_W-1:0] : (we_q ? wa_q : cur_addr);

    always_ff @(posedge clk) begin
        if (rst || !prog_act) begin
            enabled_q   <= 1'b0;
            mode_q      <= MD_HDR;
            ph_q        <= PH_OP;
            kind_q      <= K_NONE;
            hi_q        <= '0;
            lo_q        <= '0;
            pidx_q      <= '0;
            wr_cnt_q    <= '0;
            er_cnt_q    <= '0;
            sweep_q     <= '0;
            poll_addr_q <= '0;
            poll_dat_q  <= '0;
            wa_q        <= '0;
            wd_q        <= '0;
            we_q        <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (wr_busy)  wr_cnt_q <= wr_cnt_q - WR_CW'(1);
            if (er_busy)  er_cnt_q <= er_cnt_q - ER_CW'(1);
            if (sweep_on) sweep_q  <= sweep_q + (ADDR_W+1)'(1);
            if (byte_done) begin
                if (mode_q == MD_PAGE) begin
                    if (kind_q == K_WRP && !er_busy) begin
                        we_q        <= 1'b1;
                        wa_q        <= page_waddr;
                        wd_q        <= rx_byte;
                        poll_addr_q <= page_waddr;
                        poll_dat_q  <= rx_byte;
                        wr_cnt_q    <= WR_CW'(WR_BUSY);
                    end
                    pidx_q <= pidx_q + 8'd1;
                    if (pidx_q == 8'(PAGE_LEN - 1))
                        mode_q <= MD_HDR;
                end else begin
                    unique case (ph_q)
                        PH_OP: begin
                            kind_q <= classify(rx_byte, OP_ENABLE, OP_ERASE, OP_RD_BYTE,
                                               OP_WR_BYTE, OP_RD_PAGE, OP_WR_PAGE);
                            ph_q   <= PH_HI;
                        end
                        PH_HI: begin
                            hi_q <= rx_byte[HI_W-1:0];
                            if (enabled_q && (kind_q == K_RDP || kind_q == K_WRP)) begin
                                mode_q <= MD_PAGE;
                                pidx_q <= '0;
                                ph_q   <= PH_OP;
                            end else begin
                                ph_q <= PH_LO;
                            end
                        end
                        PH_LO: begin
                            lo_q <= rx_byte;
                            ph_q <= PH_DAT;
                        end
                        PH_DAT: begin
                            ph_q <= PH_OP;
                            if (kind_q == K_EN) begin
                                enabled_q <= 1'b1;
                            end else if (kind_q == K_ERASE && enabled_q && !er_busy) begin
                                er_cnt_q <= ER_CW'(ER_TIME);
                                sweep_q  <= '0;
                            end else if (kind_q == K_WRB && enabled_q && !er_busy) begin
                                we_q        <= 1'b1;
                                wa_q        <= {hi_q, lo_q};
                                wd_q        <= rx_byte;
                                poll_addr_q <= {hi_q, lo_q};
                                poll_dat_q  <= rx_byte;
                                wr_cnt_q    <= WR_CW'(WR_BUSY);
                            end
                        end
                        default: ph_q <= PH_OP;
                    endcase
                end
            end
        end
    end

    AST_WE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> enabled_q); // R2
    AST_NO_WRITE_IN_ERASE: assert property (@(posedge clk) disable iff (rst)
        er_busy |-> !we_q); // R11
    AST_WRITE_TIMED: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !sweep_on) |-> wr_busy); // R6
    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (prog_act && mode_q == MD_PAGE && !byte_done) |=> $stable(pidx_q)); // R8

endmodule

// File: rtl/isp_slave.sv
module isp_slave
    import isp_pkg::*;
#(
    parameter int          ADDR_W       = 11,
    parameter int          GUARD_CYCLES = 64,
    parameter int          WR_BUSY      = 1500,
    parameter int          ER_BUSY      = 4000,
    parameter logic [7:0]  OP_ENABLE    = 8'hAC,
    parameter logic [7:0]  OP_ERASE     = 8'h8A,
    parameter logic [7:0]  OP_RD_BYTE   = 8'h20,
    parameter logic [7:0]  OP_WR_BYTE   = 8'h40,
    parameter logic [7:0]  OP_RD_PAGE   = 8'h30,
    parameter logic [7:0]  OP_WR_PAGE   = 8'h50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_req,
    input  logic              sck,
    input  logic              mosi,
    output logic              miso,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    input  logic [7:0]        mem_rdata
);
    logic  rise, fall, bit_s, byte_done;
    byte_t rx_byte, tx_byte;

    isp_sampler #(
        .GUARD_CYCLES (GUARD_CYCLES),
        .SYNC_STAGES  (2)
    ) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .prog_act (prog_req),
        .sck      (sck),
        .mosi     (mosi),
        .rise_o   (rise),
        .fall_o   (fall),
        .bit_o    (bit_s)
    );

    isp_shifter u_shifter (
        .clk       (clk),
        .rst       (rst),
        .prog_act  (prog_req),
        .rise      (rise),
        .fall      (fall),
        .bit_in    (bit_s),
        .tx_byte   (tx_byte),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso      (miso)
    );

    isp_engine #(
        .ADDR_W     (ADDR_W),
        .WR_BUSY    (WR_BUSY),
        .ER_BUSY    (ER_BUSY),
        .OP_ENABLE  (OP_ENABLE),
        .OP_ERASE   (OP_ERASE),
        .OP_RD_BYTE (OP_RD_BYTE),
        .OP_WR_BYTE (OP_WR_BYTE),
        .OP_RD_PAGE (OP_RD_PAGE),
        .OP_WR_PAGE (OP_WR_PAGE)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .prog_act  (prog_req),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .tx_byte   (tx_byte),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata)
    );

endmodule

// File: tb/test_isp_slave.sv
module test_isp_slave;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 11;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int WR_BUSY    = 1500;
    localparam int ER_BUSY    = 4000;
    localparam int HALF_SCK   = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              prog_req = 1'b0;
    logic              sck = 1'b0;
    logic              mosi = 1'b0;
    logic              miso;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic              mem_we;
    logic [7:0]        mem_rdata;

    logic [7:0] mem [DEPTH];

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    logic [8:0] exp_q [$];
    string      req_q [$];
    logic [7:0] rx_last;
    event       got_byte;

    always #(CLK_PERIOD/2) clk = ~clk;

    isp_slave #(
        .ADDR_W  (ADDR_W),
        .WR_BUSY (WR_BUSY),
        .ER_BUSY (ER_BUSY)
    ) i_isp_slave (
        .clk       (clk),
        .rst       (rst),
        .prog_req  (prog_req),
        .sck       (sck),
        .mosi      (mosi),
        .miso      (miso),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    function automatic logic [7:0] init_val(int a);
        return 8'((a * 13 + 7) & 255);
    endfunction

    function automatic logic [7:0] page_val(int k);
        return 8'(((k * 3) & 255) ^ 8'h5A);
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // monitor: pops the expected item for every byte the driver completes
    initial begin
        forever begin
            @(got_byte);
            if (exp_q.size() != 0) begin
                logic [8:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                if (e[8]) check(rx_last, e[7:0], r);
            end
        end
    end

    task automatic xbyte(input logic [7:0] b, input bit chk, input logic [7:0] exp, input string req);
        logic [7:0] rx;
        exp_q.push_back({chk, exp});
        req_q.push_back(req);
        for (int i = 7; i >= 0; i--) begin
            mosi = b[i];
            repeat (HALF_SCK) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            repeat (HALF_SCK) @(negedge clk);
            sck = 1'b0;
        end
        rx_last = rx;
        -> got_byte;
    endtask

    task automatic instr(input logic [7:0] op, input int addr, input logic [7:0] d,
                         input bit chk, input logic [7:0] exp, input string req);
        xbyte(op, 1'b0, 8'h00, req);
        xbyte(8'(addr >> 8), 1'b0, 8'h00, req);
        xbyte(8'(addr & 255), 1'b0, 8'h00, req);
        xbyte(d, chk, exp, req);
    endtask

    task automatic rd(input int addr, input logic [7:0] exp, input string req);
        instr(8'h20, addr, 8'h00, 1'b1, exp, req);
    endtask

    task automatic wr(input int addr, input logic [7:0] d);
        instr(8'h40, addr, d, 1'b0, 8'h00, "R4");
    endtask

    task automatic start_session();
        @(negedge clk);
        prog_req = 1'b1;
        repeat (80) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int bad;
        for (int i = 0; i < DEPTH; i++) mem[i] = init_val(i);

        // reset state (R10)
        repeat (5) @(negedge clk);
        check({7'b0, miso}, 8'h00, "R10 reset miso");
        check({7'b0, mem_we}, 8'h00, "R10 reset write strobe");
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // session start with early clock edges inside the guard window (R9)
        prog_req = 1'b1;
        repeat (4) @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            mosi = 1'b1;
            sck = 1'b1; repeat (6) @(negedge clk);
            sck = 1'b0; repeat (6) @(negedge clk);
        end
        mosi = 1'b0;
        repeat (60) @(negedge clk);

        // gated before enable (R2)
        wr(5, 8'h5A);
        rd(5, 8'h00, "R2 read before enable");
        instr(8'hAC, 0, 8'h00, 1'b0, 8'h00, "R2");
        rd(5, init_val(5), "R2/R9 write before enable ignored, framing intact");
        rd(1, init_val(1), "R5 read byte");
        rd(12'h7FF, init_val(12'h7FF), "R1 top address");

        // write then data polling (R6, R4)
        wr(12'h123, 8'h37);
        rd(12'h123, 8'h80, "R6 polling MSB complement");
        rd(12'h124, init_val(12'h124), "R6 other address true data");
        repeat (WR_BUSY + 100) @(negedge clk);
        rd(12'h123, 8'h37, "R4 written data after busy");
        wr(12'h200, 8'hC4);
        rd(12'h200, 8'h00, "R6 polling MSB one");
        repeat (WR_BUSY + 100) @(negedge clk);
        rd(12'h200, 8'hC4, "R4 second write");
        // high byte bits above the address width are ignored (R1)
        rd(12'hA00, 8'hC4, "R1 high byte masking");

        // page read of page 2 (R7)
        xbyte(8'h30, 1'b0, 8'h00, "R7");
        xbyte(8'h02, 1'b0, 8'h00, "R7");
        for (int k = 0; k < 256; k++)
            xbyte(8'h00, 1'b1, (k == 0) ? 8'hC4 : init_val(12'h200 + k), "R7 page read");

        // page write of page 5 (R8)
        xbyte(8'h50, 1'b0, 8'h00, "R8");
        xbyte(8'h05, 1'b0, 8'h00, "R8");
        for (int k = 0; k < 256; k++)
            xbyte(page_val(k), 1'b0, 8'h00, "R8");
        rd(12'h4FF, init_val(12'h4FF), "R8 next instruction decoded after page");
        repeat (WR_BUSY + 100) @(negedge clk);
        rd(12'h500, page_val(0), "R8 first page byte");
        rd(12'h5FF, page_val(255), "R8 last page byte");
        bad = 0;
        for (int k = 0; k < 256; k++) if (mem[12'h500 + k] !== page_val(k)) bad++;
        check(8'(bad), 8'h00, "R8 page contents mismatches");

        // erase (R3, R11)
        instr(8'h8A, 0, 8'h00, 1'b0, 8'h00, "R3");
        rd(5, 8'h00, "R3 read during erase");
        wr(12'h010, 8'h11);
        repeat (ER_BUSY + 100) @(negedge clk);
        rd(5, 8'hFF, "R3 erased value");
        rd(12'h010, 8'hFF, "R11 write during erase ignored");
        bad = 0;
        for (int i = 0; i < DEPTH; i++) if (mem[i] !== 8'hFF) bad++;
        check(8'(bad > 255 ? 255 : bad), 8'h00, "R3 locations not erased");

        // abort of a partial read (R10)
        xbyte(8'h20, 1'b0, 8'h00, "R10");
        xbyte(8'h00, 1'b0, 8'h00, "R10");
        xbyte(8'h05, 1'b0, 8'h00, "R10");
        repeat (HALF_SCK) @(negedge clk);
        check({7'b0, miso}, 8'h01, "R5 first data bit on line");
        for (int i = 0; i < 3; i++) begin
            sck = 1'b1; repeat (HALF_SCK) @(negedge clk);
            sck = 1'b0; repeat (HALF_SCK) @(negedge clk);
        end
        prog_req = 1'b0;
        repeat (4) @(negedge clk);
        check({7'b0, miso}, 8'h00, "R10 miso released");
        repeat (10) @(negedge clk);
        start_session();
        rd(5, 8'h00, "R10 enabled state cleared");
        instr(8'hAC, 0, 8'h00, 1'b0, 8'h00, "R10");
        rd(5, 8'hFF, "R10 framing restarted after abort");

        repeat (20) @(negedge clk);
        finish_run();
    end

endmodule